// File: doc/BRIEF.md
# Supply Rail Voltage Command Controller

This block sits between a power sequencer and an external power management IC. The sequencer asks for a supply rail to be switched on or off. The controller passes that request on in one of two ways.

- **Serial mode.** It issues a command on a valid/ready command port. The command carries the rail index and a target voltage code, and a separate serial bus engine consumes it.
- **Legacy mode.** It drives a dedicated active-low mode pin for each rail. When a pin is released, the power IC goes back to the level it last held.

After the command has been handed over, the block returns a single-cycle acknowledge to the sequencer.

A small configuration store holds the following fields, written through a plain write port:
- one register per rail, whose bits [31:24] carry that rail's on-voltage code;
- a control register, whose bit 4 chooses legacy pin operation.

Only one request is in flight at a time. A new request waits for the previous acknowledge.

Top module: `rail_vcmd_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0, `ack` is 0, every `mode_pin_n` bit is 1 (released), and the control register selects serial mode.
- R2: In serial mode, an accepted on request raises `cmd_valid` on the next cycle. `cmd_rail` equals the requested rail, and `cmd_code` equals bits [31:24] last written to that rail's register. The rail registers sit at `cfg_addr` = 1 + rail index.
- R3: In serial mode, an accepted off request issues a command whose `cmd_code` is 8'h00.
- R4: In serial mode, `ack` is 1 for exactly one cycle. That cycle follows the clock edge where `cmd_valid` and `cmd_ready` are both 1, and `cmd_valid` is 0 in that same cycle.
- R5: When bit 4 of the control register (`cfg_addr` = 0) is 1, an on request drives the rail's `mode_pin_n` to 1 on the next cycle, and no command is issued.
- R6: In legacy mode, an off request drives the rail's `mode_pin_n` to 0, and the other rail's pin keeps its value.
- R7: In legacy mode, `ack` is 1 for one cycle, starting one cycle after the pin changes.
- R8: `req_ready` is 0 from the cycle after an accepted request until the cycle in which `ack` is 1. A request offered while busy is ignored and produces no command or pin change.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_rail` and `cmd_code` hold their values.
- R10: A configuration write made while a command is outstanding does not alter that command. Both the voltage code and the mode choice are fixed when the request is accepted.
- R11: Serial mode requests leave every `mode_pin_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 = control register, 1 + n = rail n register |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Sequencer request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_rail | input | 1 | Rail index of the request |
| req_on | input | 1 | 1 = switch rail on, 0 = switch rail off |
| ack | output | 1 | One-cycle acknowledge that the request was issued |
| cmd_valid | output | 1 | Serial command valid |
| cmd_ready | input | 1 | Serial engine accepts the command |
| cmd_rail | output | 1 | Rail index carried by the command |
| cmd_code | output | 8 | Target voltage code carried by the command |
| mode_pin_n | output | 2 | Active-low legacy mode pin, one per rail |

## Verification
The hardest situations to reach involve an outstanding serial command. One is a second request arriving while the command waits. The other is the configuration being rewritten underneath it. Both can only arise while the serial engine withholds `cmd_ready`.

The bench therefore keeps `cmd_ready` low for several cycles. During that window it offers a competing request and then withdraws it. It also rewrites both the rail code and the mode bit. It then confirms three things: the pending command kept its original fields, the acknowledge arrived on time, and no stray command followed.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_PIN  = 2'd2
  } rvc_state_e;

endpackage

// File: rtl/rvc_cfg_regs.sv
module rvc_cfg_regs #(
  parameter int NUM_RAILS = 2,
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 8,
  parameter int CODE_LSB  = 24,
  parameter int MODE_BIT  = 4,
  localparam int ADDR_W   = $clog2(NUM_RAILS + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic [NUM_RAILS-1:0][CODE_W-1:0]  on_code,
  output logic                              legacy_mode
);

  // Control register: only the mode-select bit is stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      legacy_mode <= 1'b0;
    end else if (cfg_we && cfg_addr == '0) begin
      legacy_mode <= cfg_wdata[MODE_BIT];
    end
  end

  // One register per rail, at address 1 + rail index; only the code field is kept.
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        on_code[g] <= '0;
      end else if (cfg_we && cfg_addr == ADDR_W'(g + 1)) begin
        on_code[g] <= cfg_wdata[CODE_LSB +: CODE_W];
      end
    end
  end

  // Bits of the write word that are not stored.
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

endmodule

// File: rtl/rvc_seq.sv
module rvc_seq
  import rvc_pkg::*;
#(
  parameter int NUM_RAILS    = 2,
  parameter int CODE_W       = 8,
  parameter logic [7:0] OFF_CODE = 8'h00,
  localparam int RAIL_W      = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_RAILS-1:0][CODE_W-1:0]  on_code,
  input  logic                              legacy_mode,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [RAIL_W-1:0]                 req_rail,
  input  logic                              req_on,
  output logic                              ack,
  output logic                              cmd_valid,
  input  logic                              cmd_ready,
  output logic [RAIL_W-1:0]                 cmd_rail,
  output logic [CODE_W-1:0]                 cmd_code,
  output logic                              pin_upd,
  output logic [RAIL_W-1:0]                 pin_rail,
  output logic                              pin_level
);

  rvc_state_e  state_q;
  logic        take;

  assign req_ready = (state_q == ST_IDLE);
  assign take      = req_ready && req_valid;

  // A legacy request is handed to the pin register in the acceptance cycle.
  assign pin_upd   = take && legacy_mode;
  assign pin_rail  = req_rail;
  assign pin_level = req_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cmd_valid <= 1'b0;
      cmd_rail  <= '0;
      cmd_code  <= '0;
      ack       <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            if (legacy_mode) begin
              state_q <= ST_PIN;
            end else begin
              cmd_valid <= 1'b1;
              cmd_rail  <= req_rail;
              cmd_code  <= req_on ? on_code[req_rail] : OFF_CODE[CODE_W-1:0];
              state_q   <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            ack       <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_PIN: begin
          ack     <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_rail)); // R9
  AST_SERIAL_ACK: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> ack && !cmd_valid); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R4
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready); // R8
  AST_LEGACY_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    pin_upd |=> !cmd_valid); // R5
  AST_LEGACY_ACK: assert property (@(posedge clk) disable iff (rst)
    pin_upd |=> !ack ##1 ack); // R7

endmodule

// File: rtl/rvc_pins.sv
module rvc_pins #(
  parameter int NUM_RAILS = 2,
  localparam int RAIL_W   = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pin_upd,
  input  logic [RAIL_W-1:0]    pin_rail,
  input  logic                 pin_level,
  output logic [NUM_RAILS-1:0] mode_pin_n
);

  // Each pin is a registered output; 1 = released (rail at its programmed level).
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_pin_n[g] <= 1'b1;
      end else if (pin_upd && pin_rail == RAIL_W'(g)) begin
        mode_pin_n[g] <= pin_level;
      end
    end
  end

  AST_PIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_pin_n ^ $past(mode_pin_n)) <= 1); // R6
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pin_upd |=> $stable(mode_pin_n)); // R11

endmodule

// File: rtl/rail_vcmd_ctrl.sv
module rail_vcmd_ctrl #(
  parameter int NUM_RAILS = 2,
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 8,
  parameter int CODE_LSB  = 24,
  parameter int MODE_BIT  = 4,
  localparam int RAIL_W   = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1,
  localparam int ADDR_W   = $clog2(NUM_RAILS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [RAIL_W-1:0]    req_rail,
  input  logic                 req_on,
  output logic                 ack,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [RAIL_W-1:0]    cmd_rail,
  output logic [CODE_W-1:0]    cmd_code,
  output logic [NUM_RAILS-1:0] mode_pin_n
);

  logic [NUM_RAILS-1:0][CODE_W-1:0] on_code;
  logic                             legacy_mode;
  logic                             pin_upd;
  logic [RAIL_W-1:0]                pin_rail;
  logic                             pin_level;

  rvc_cfg_regs #(
    .NUM_RAILS (NUM_RAILS),
    .DATA_W    (DATA_W),
    .CODE_W    (CODE_W),
    .CODE_LSB  (CODE_LSB),
    .MODE_BIT  (MODE_BIT)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .on_code     (on_code),
    .legacy_mode (legacy_mode)
  );

  rvc_seq #(
    .NUM_RAILS (NUM_RAILS),
    .CODE_W    (CODE_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .on_code     (on_code),
    .legacy_mode (legacy_mode),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_rail    (req_rail),
    .req_on      (req_on),
    .ack         (ack),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_rail    (cmd_rail),
    .cmd_code    (cmd_code),
    .pin_upd     (pin_upd),
    .pin_rail    (pin_rail),
    .pin_level   (pin_level)
  );

  rvc_pins #(
    .NUM_RAILS (NUM_RAILS)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .pin_upd    (pin_upd),
    .pin_rail   (pin_rail),
    .pin_level  (pin_level),
    .mode_pin_n (mode_pin_n)
  );

endmodule

// File: tb/rail_vcmd_ctrl_tb.sv
module rail_vcmd_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic        req_rail;
  logic        req_on;
  logic        ack;
  logic        cmd_valid;
  logic        cmd_ready;
  logic        cmd_rail;
  logic [7:0]  cmd_code;
  logic [1:0]  mode_pin_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rail_vcmd_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_rail(req_rail), .req_on(req_on),
    .ack(ack), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rail(cmd_rail),
    .cmd_code(cmd_code), .mode_pin_n(mode_pin_n)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Serial request; cmd_ready held low for 'wait_n' cycles before acceptance.
  task automatic serial_req(input logic rail, input logic on, input int exp_code,
                            input int wait_n, input string tag);
    logic [1:0] pins_before;
    @(negedge clk);
    pins_before = mode_pin_n;
    req_valid = 1'b1; req_rail = rail; req_on = on;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd_valid, 1, {tag, " valid"});
    chk(cmd_rail, rail, {tag, " rail"});
    chk(cmd_code, exp_code, {tag, " code"});
    chk(req_ready, 0, "R8 busy");
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk(cmd_valid, 1, "R9 hold valid");
      chk(cmd_code, exp_code, "R9 hold code");
      chk(ack, 0, "R4 no early ack");
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(ack, 1, "R4 ack");
    chk(cmd_valid, 0, "R4 valid drop");
    chk(req_ready, 1, "R8 ready again");
    chk(mode_pin_n, pins_before, "R11 pins untouched");
    @(negedge clk);
    chk(ack, 0, "R4 ack one cycle");
  endtask

  task automatic legacy_req(input logic rail, input logic on, input int exp_pins,
                            input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_rail = rail; req_on = on;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mode_pin_n, exp_pins, {tag, " pins"});
    chk(cmd_valid, 0, "R5 no command");
    chk(ack, 0, "R7 ack not yet");
    chk(req_ready, 0, "R8 busy legacy");
    @(negedge clk);
    chk(ack, 1, "R7 ack");
    chk(req_ready, 1, "R8 ready legacy");
    @(negedge clk);
    chk(ack, 0, "R7 ack one cycle");
    chk(cmd_valid, 0, "R5 still no command");
  endtask

  task automatic t_reset;
    chk(req_ready, 1, "R1 ready");
    chk(cmd_valid, 0, "R1 cmd_valid");
    chk(ack, 0, "R1 ack");
    chk(mode_pin_n, 2'b11, "R1 pins");
  endtask

  task automatic t_busy_and_cfg;
    // Outstanding command on rail 0 with code 5A; rewrite config and offer a competing request.
    @(negedge clk);
    req_valid = 1'b1; req_rail = 1'b0; req_on = 1'b1;
    @(negedge clk);
    req_rail = 1'b1; req_on = 1'b0;           // competing request while busy
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'hC3000000;
    @(negedge clk);
    cfg_addr = 2'd0; cfg_wdata = 32'h10;      // flip to legacy underneath
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(cmd_valid, 1, "R10 still pending");
    chk(cmd_rail, 0, "R10 rail kept");
    chk(cmd_code, 8'h5A, "R10 code kept");
    chk(mode_pin_n, 2'b11, "R8 ignored request no pin");
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(ack, 1, "R4 ack after busy");
    @(negedge clk);
    chk(cmd_valid, 0, "R8 ignored request no command");
    chk(ack, 0, "R8 no extra ack");
    chk(mode_pin_n, 2'b11, "R8 pins after busy");
    cfg_write(2'd0, 32'h0);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_rail = 1'b0; req_on = 1'b0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    cfg_write(2'd1, 32'h5A00FFFF);
    cfg_write(2'd2, 32'hA5000010);
    serial_req(1'b0, 1'b1, 8'h5A, 0, "R2 rail0 on");
    serial_req(1'b1, 1'b1, 8'hA5, 3, "R2 rail1 on");
    serial_req(1'b1, 1'b0, 8'h00, 1, "R3 rail1 off");
    t_busy_and_cfg();
    serial_req(1'b0, 1'b1, 8'hC3, 0, "R10 new code used");
    cfg_write(2'd0, 32'h00000010);
    legacy_req(1'b1, 1'b0, 2'b01, "R6 rail1 off");
    legacy_req(1'b0, 1'b0, 2'b00, "R6 rail0 off");
    legacy_req(1'b1, 1'b1, 2'b10, "R5 rail1 on");
    legacy_req(1'b0, 1'b1, 2'b11, "R5 rail0 on");
    cfg_write(2'd0, 32'h0);
    serial_req(1'b1, 1'b0, 8'h00, 2, "R3 back to serial");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule